// File: doc/BRIEF.md
# Predicated Element Issue Sequencer

This block turns one vectorised scalar operation into a stream of per-element operations for a row of parallel ALU lanes. An operation is described by a vector length, a predicate bitmask, a flag per operand (destination and two sources) that says whether that operand is a vector or a scalar, and the base register number of each operand. When the block is idle and `start` is high, the description is captured. From the next clock edge on, the block emits one group of lane slots per cycle. Each slot carries an element's destination and source register numbers, a valid bit and a zero-write flag.

Disabled elements are skipped. The enabled elements are packed onto the lowest lanes, so a sparse mask finishes in fewer cycles. With zeroing selected, every element below the vector length is emitted in order, and the disabled ones are marked as zero-writes. An operation whose three operands are all scalar takes a fast path. The block detects this at capture time and issues it once, as element 0.

Top module: `elem_issue_seq`

## Requirements
- R1: An operation is captured only on a rising edge where `busy` is low and `start` is high. `busy` rises on that edge and stays high until the edge that emits the final slot group. A `start` seen while `busy` is high is ignored: the running operation's slots are unchanged and no further operation follows it.
- R2: In skip mode (`zero_en`=0), element i (0 ≤ i < VL) is issued exactly when bit i of `pmask` is 1. When `pred_en`=0 the mask is taken as all ones.
- R3: For element i, a vector operand's register number is its base plus i, modulo 2^REG_W. A scalar operand's register number is its base for every element.
- R4: Each cycle the lowest-numbered elements not yet issued go out in ascending order on lanes 0, 1, 2, and so on. Valid lanes are always contiguous from lane 0, and every group except the last fills all lanes. With 4 lanes, VL=8 and mask 0xDB, the first group holds elements 0,1,3,4 and the second holds elements 6,7.
- R5: With `zero_en`=1, every element i < VL is issued in order, packed as in R4. `slot_zero` is 1 exactly for the elements whose predicate bit is 0, and is never 1 on an invalid lane.
- R6: When all three vector flags are 0, the operation completes in one issue cycle with at most one valid slot, on lane 0, as element 0 with the three base registers. VL is ignored. Predication and zeroing apply to bit 0 only.
- R7: The first slot group appears on the first rising edge after capture. `done` is high for exactly one cycle, together with the final group. An operation with no element to issue still produces one cycle with `done` high and no valid lane.
- R8: While `rst` is high, and after it is released, `busy`, `done`, `slot_valid` and `slot_zero` are all 0 until an operation is captured.
- R9: Elements at positions i ≥ VL are never issued, whatever the mask bits above VL. VL may range from 1 to MAX_VL (32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to capture a new operation |
| vl | input | 6 | Vector length, 1..32 |
| pmask | input | 32 | Predicate bitmask, bit i enables element i |
| pred_en | input | 1 | 1: use `pmask`; 0: all elements enabled |
| zero_en | input | 1 | 1: emit zero-writes for disabled elements |
| vec_rd | input | 1 | Destination is a vector |
| vec_rs1 | input | 1 | First source is a vector |
| vec_rs2 | input | 1 | Second source is a vector |
| base_rd | input | 6 | Destination base register |
| base_rs1 | input | 6 | First source base register |
| base_rs2 | input | 6 | Second source base register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final slot group is on the outputs this cycle |
| slot_valid | output | 4 | Per-lane valid |
| slot_zero | output | 4 | Per-lane zero-write flag |
| slot_rd | output | 24 | Per-lane destination register, lane k at bits [6k+5:6k] |
| slot_rs1 | output | 24 | Per-lane first source register |
| slot_rs2 | output | 24 | Per-lane second source register |

## Verification
Two functions share a cycle in this block. In zero mode, zero-write slots and ordinary enabled slots are packed into the same lane group. The final group also coincides with the one-cycle `done` pulse and the fall of `busy`. The stimulus table provokes both with masks whose disabled positions fall inside a group, for example 0xDB with zeroing, and with operations whose element count is not a multiple of the lane count. Each emitted group is compared lane by lane against an element list built from the requirements, with the zero flag included. In the same sample, `done` and `busy` must mark exactly the expected last cycle.

// File: rtl/isq_pkg.sv
package isq_pkg;

  localparam int unsigned DEF_REG_W = 6;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } seq_state_t;

endpackage

// File: rtl/isq_mask_prep.sv
module isq_mask_prep #(
  parameter int unsigned N  = 32,
  parameter int unsigned VW = 6
) (
  input  logic [VW-1:0] vl,
  input  logic [N-1:0]  pmask,
  input  logic          pred_en,
  input  logic          zero_en,
  input  logic          all_scalar,
  output logic [N-1:0]  issue_mask,
  output logic [N-1:0]  zero_mask
);

  logic [N-1:0] in_range;
  logic [N-1:0] enabled;

  for (genvar i = 0; i < N; i++) begin : g_elem
    if (i == 0) begin : g_first
      // scalar fast path always covers element 0 only
      assign in_range[i] = all_scalar | (vl != '0);
    end else begin : g_rest
      assign in_range[i] = ~all_scalar & (VW'(i) < vl);
    end
    assign enabled[i]    = pred_en ? pmask[i] : 1'b1;
    assign issue_mask[i] = in_range[i] & (enabled[i] | zero_en);
    assign zero_mask[i]  = in_range[i] & ~enabled[i] & zero_en;
  end

endmodule

// File: rtl/isq_elem_pick.sv
module isq_elem_pick #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = 5
) (
  input  logic [N-1:0]  pend,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  rest
);

  always_comb begin
    found = |pend;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
    rest = pend;
    if (found) rest[idx] = 1'b0;
  end

endmodule

// File: rtl/isq_reg_map.sv
module isq_reg_map #(
  parameter int unsigned RW = 6,
  parameter int unsigned IW = 5
) (
  input  logic          vec,
  input  logic [RW-1:0] base,
  input  logic [IW-1:0] elem,
  output logic [RW-1:0] reg_idx
);

  assign reg_idx = vec ? (base + RW'(elem)) : base;

endmodule

// File: rtl/elem_issue_seq.sv
module elem_issue_seq
  import isq_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned MAX_VL = 32,
  parameter int unsigned REG_W  = DEF_REG_W,
  parameter int unsigned VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [VL_W-1:0]        vl,
  input  logic [MAX_VL-1:0]      pmask,
  input  logic                   pred_en,
  input  logic                   zero_en,
  input  logic                   vec_rd,
  input  logic                   vec_rs1,
  input  logic                   vec_rs2,
  input  logic [REG_W-1:0]       base_rd,
  input  logic [REG_W-1:0]       base_rs1,
  input  logic [REG_W-1:0]       base_rs2,
  output logic                   busy,
  output logic                   done,
  output logic [LANES-1:0]       slot_valid,
  output logic [LANES-1:0]       slot_zero,
  output logic [LANES*REG_W-1:0] slot_rd,
  output logic [LANES*REG_W-1:0] slot_rs1,
  output logic [LANES*REG_W-1:0] slot_rs2
);

  localparam int unsigned IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;

  seq_state_t        state_q;
  logic [MAX_VL-1:0] pend_q;
  logic [MAX_VL-1:0] zmask_q;
  logic              vd_q, v1_q, v2_q;
  logic [REG_W-1:0]  bd_q, b1_q, b2_q;

  logic              all_scalar;
  logic [MAX_VL-1:0] issue_m;
  logic [MAX_VL-1:0] zero_m;

  assign all_scalar = ~(vec_rd | vec_rs1 | vec_rs2);

  isq_mask_prep #(
    .N (MAX_VL),
    .VW(VL_W)
  ) u_prep (
    .vl        (vl),
    .pmask     (pmask),
    .pred_en   (pred_en),
    .zero_en   (zero_en),
    .all_scalar(all_scalar),
    .issue_mask(issue_m),
    .zero_mask (zero_m)
  );

  // chain of lowest-set-bit pickers, one per lane
  logic [LANES:0][MAX_VL-1:0]  chain;
  logic [LANES-1:0][IDX_W-1:0] lane_idx;
  logic [LANES-1:0]            lane_found;
  logic [LANES-1:0]            lane_zero;
  logic [LANES*REG_W-1:0]      lane_rd, lane_rs1, lane_rs2;

  assign chain[0] = pend_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    isq_elem_pick #(
      .N (MAX_VL),
      .IW(IDX_W)
    ) u_pick (
      .pend (chain[k]),
      .found(lane_found[k]),
      .idx  (lane_idx[k]),
      .rest (chain[k+1])
    );

    assign lane_zero[k] = lane_found[k] & zmask_q[lane_idx[k]];

    isq_reg_map #(.RW(REG_W), .IW(IDX_W)) u_map_rd (
      .vec(vd_q), .base(bd_q), .elem(lane_idx[k]),
      .reg_idx(lane_rd[k*REG_W +: REG_W])
    );
    isq_reg_map #(.RW(REG_W), .IW(IDX_W)) u_map_rs1 (
      .vec(v1_q), .base(b1_q), .elem(lane_idx[k]),
      .reg_idx(lane_rs1[k*REG_W +: REG_W])
    );
    isq_reg_map #(.RW(REG_W), .IW(IDX_W)) u_map_rs2 (
      .vec(v2_q), .base(b2_q), .elem(lane_idx[k]),
      .reg_idx(lane_rs2[k*REG_W +: REG_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      pend_q     <= '0;
      zmask_q    <= '0;
      vd_q       <= 1'b0;
      v1_q       <= 1'b0;
      v2_q       <= 1'b0;
      bd_q       <= '0;
      b1_q       <= '0;
      b2_q       <= '0;
      done       <= 1'b0;
      slot_valid <= '0;
      slot_zero  <= '0;
      slot_rd    <= '0;
      slot_rs1   <= '0;
      slot_rs2   <= '0;
    end else begin
      done       <= 1'b0;
      slot_valid <= '0;
      slot_zero  <= '0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_ISSUE;
            pend_q  <= issue_m;
            zmask_q <= zero_m;
            vd_q    <= vec_rd;
            v1_q    <= vec_rs1;
            v2_q    <= vec_rs2;
            bd_q    <= base_rd;
            b1_q    <= base_rs1;
            b2_q    <= base_rs2;
          end
        end
        ST_ISSUE: begin
          slot_valid <= lane_found;
          slot_zero  <= lane_zero;
          slot_rd    <= lane_rd;
          slot_rs1   <= lane_rs1;
          slot_rs2   <= lane_rs2;
          pend_q     <= chain[LANES];
          if (chain[LANES] == '0) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q == ST_ISSUE);

  // ---------------- assertions ----------------
  for (genvar k = 0; k + 1 < LANES; k++) begin : g_chk_contig
    a_r4_lanes_contig: assert property (@(posedge clk) disable iff (rst)
      slot_valid[k+1] |-> slot_valid[k]);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_chk_zero
    a_r5_zero_on_valid: assert property (@(posedge clk) disable iff (rst)
      slot_zero[k] |-> slot_valid[k]);
  end

  a_r4_full_groups: assert property (@(posedge clk) disable iff (rst)
    ((|slot_valid) && !done) |-> (&slot_valid));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r1_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r1_no_slots_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> (slot_valid == '0));

  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: tb/test_elem_issue_seq.sv
module test_elem_issue_seq;

  localparam int LANES = 4;
  localparam int RW    = 6;

  typedef struct packed {
    logic [5:0]  vl;
    logic [31:0] mask;
    logic        pe, ze, vd, v1, v2;
    logic [5:0]  bd, b1, b2;
    logic [6:0]  exp_n;
  } op_t;

  // stimulus and expected element counts
  localparam op_t TBL [11] = '{
    '{6'd8,  32'h0000_00DB, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 6'd10, 6'd20, 6'd30, 7'd6},  // R4 packing
    '{6'd8,  32'h0000_00DB, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'd10, 6'd20, 6'd30, 7'd8},  // R5 zero mode
    '{6'd32, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'd40, 6'd50, 6'd60, 7'd32}, // R2 no pred, R3 wrap, R9 max VL
    '{6'd5,  32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6'd2,  6'd7,  6'd62, 7'd5},  // R3 mixed operands
    '{6'd20, 32'h0000_FFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd9,  6'd11, 6'd13, 7'd1},  // R6 fast path
    '{6'd20, 32'hFFFF_FFFE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd9,  6'd11, 6'd13, 7'd0},  // R6 masked scalar
    '{6'd16, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 6'd1,  6'd2,  6'd3,  7'd0},  // R7 empty
    '{6'd3,  32'hFFFF_FFF0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 6'd1,  6'd2,  6'd3,  7'd0},  // R9 bits above VL
    '{6'd12, 32'h0000_0A50, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 6'd0,  6'd16, 6'd33, 7'd4},  // R2 sparse
    '{6'd1,  32'h0000_0001, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd5,  6'd6,  6'd7,  7'd1},  // R9 VL=1
    '{6'd9,  32'h0000_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd4,  6'd5,  6'd6,  7'd1}   // R6 scalar zero-write
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [5:0]  vl = '0;
  logic [31:0] pmask = '0;
  logic pred_en = 1'b0, zero_en = 1'b0;
  logic vec_rd = 1'b0, vec_rs1 = 1'b0, vec_rs2 = 1'b0;
  logic [5:0] base_rd = '0, base_rs1 = '0, base_rs2 = '0;
  logic busy, done;
  logic [LANES-1:0] slot_valid, slot_zero;
  logic [LANES*RW-1:0] slot_rd, slot_rs1, slot_rs2;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  elem_issue_seq i_elem_issue_seq (
    .clk(clk), .rst(rst), .start(start), .vl(vl), .pmask(pmask),
    .pred_en(pred_en), .zero_en(zero_en),
    .vec_rd(vec_rd), .vec_rs1(vec_rs1), .vec_rs2(vec_rs2),
    .base_rd(base_rd), .base_rs1(base_rs1), .base_rs2(base_rs2),
    .busy(busy), .done(done), .slot_valid(slot_valid), .slot_zero(slot_zero),
    .slot_rd(slot_rd), .slot_rs1(slot_rs1), .slot_rs2(slot_rs2)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] mapr(input logic v, input logic [5:0] b, input int i);
    return v ? (b + 6'(i)) : b;
  endfunction

  task automatic run_op(input op_t o, input bit poke);
    int eidx[32];
    bit ez[32];
    int n, ncyc, cyc, seen, vlen;
    bit got_done, allsc;
    allsc = !o.vd && !o.v1 && !o.v2;
    vlen  = allsc ? 1 : int'(o.vl);
    n = 0;
    for (int i = 0; i < vlen; i++) begin
      bit en;
      en = o.pe ? o.mask[i] : 1'b1;
      if (en || o.ze) begin
        eidx[n] = i;
        ez[n]   = !en;
        n++;
      end
    end
    ncyc = (n == 0) ? 1 : (n + LANES - 1) / LANES;

    @(negedge clk);
    vl = o.vl; pmask = o.mask; pred_en = o.pe; zero_en = o.ze;
    vec_rd = o.vd; vec_rs1 = o.v1; vec_rs2 = o.v2;
    base_rd = o.bd; base_rs1 = o.b1; base_rs2 = o.b2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    cyc = 0; seen = 0; got_done = 1'b0;
    while (!got_done && cyc < ncyc + 2) begin
      logic [127:0] act, exp;
      @(negedge clk);
      act = '0; exp = '0;
      for (int j = 0; j < LANES; j++) begin
        int k;
        k = cyc * LANES + j;
        act[j] = slot_valid[j];
        if (slot_valid[j]) begin
          act[8+j] = slot_zero[j];
          act[16+j*RW +: RW] = slot_rd[j*RW +: RW];
          act[48+j*RW +: RW] = slot_rs1[j*RW +: RW];
          act[80+j*RW +: RW] = slot_rs2[j*RW +: RW];
        end
        if (k < n) begin
          exp[j]   = 1'b1;
          exp[8+j] = ez[k];
          exp[16+j*RW +: RW] = mapr(o.vd, o.bd, eidx[k]);
          exp[48+j*RW +: RW] = mapr(o.v1, o.b1, eidx[k]);
          exp[80+j*RW +: RW] = mapr(o.v2, o.b2, eidx[k]);
        end
      end
      act[112] = done; act[113] = busy;
      exp[112] = (cyc == ncyc - 1); exp[113] = (cyc != ncyc - 1);
      // R2 R3 R4 R5 R6 lane contents, R7/R1 done and busy in the same cycle
      check(act == exp, "R2/R3/R4/R5/R6/R7", "slot group", act, exp);
      seen += $countones(slot_valid);
      if (done) got_done = 1'b1;
      if (poke && cyc == 1) begin
        start = 1'b1; vl = 6'd7; pmask = '1; pred_en = 1'b0; zero_en = 1'b1;
        base_rd = 6'd0; base_rs1 = 6'd0; base_rs2 = 6'd0;
      end else begin
        start = 1'b0;
      end
      cyc++;
    end
    start = 1'b0;
    check(got_done && cyc == ncyc, "R7", "issue cycles", 128'(cyc), 128'(ncyc));
    check(seen == int'(o.exp_n), "R2/R9", "issued elements", 128'(seen), 128'(o.exp_n));
    if (poke) begin
      bit quiet;
      quiet = 1'b1;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        if (busy || done || slot_valid != '0) quiet = 1'b0;
      end
      // R1 start during busy must not start another operation
      check(quiet, "R1", "idle after ignored start", 128'({busy, done, slot_valid}), 128'(0));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset values while reset is held
    check({busy, done, slot_valid, slot_zero} == '0, "R8", "reset state",
          128'({busy, done, slot_valid, slot_zero}), 128'(0));
    rst = 1'b0;
    @(negedge clk);
    check({busy, done, slot_valid, slot_zero} == '0, "R8", "after reset release",
          128'({busy, done, slot_valid, slot_zero}), 128'(0));

    for (int t = 0; t < 11; t++) run_op(TBL[t], 1'b0);

    // R1 start during busy is ignored (32-element operation, 8 groups)
    run_op(TBL[2], 1'b1);
    // back-to-back: new capture right after done
    run_op(TBL[0], 1'b0);
    run_op(TBL[1], 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule